// File: doc/BRIEF.md
# Repeated string operation sequencer

This block runs a memory string operation over a run of elements without help from the rest of the core. A start command supplies the operation, the element size, the stepping direction and the starting register values: a source pointer, a destination pointer, an element count, an accumulator, and two base values. The source base is added to the source pointer to form the read address, and the destination base is added to the destination pointer to form the write or scan address. The five operations are load, store, move, scan and compare.

For every element the sequencer makes one access, or a pair of accesses, on a simple byte-addressed memory port. It then steps the pointers that the operation uses and decrements the count. It stops when the count runs out. Scan and compare also stop as soon as two compared elements differ. When it stops, a one-cycle done pulse appears together with the final register values and a flag. The flag tells an early stop on a difference apart from a normal finish.

Top module: `strop_seq`

## Requirements
- R1: Operation codes are load=0, store=1, move=2, scan=3 and compare=4. Load reads at source base + source pointer. Store writes at destination base + destination pointer. Scan reads at the destination address. Move reads the source address and then writes the destination address. Compare reads the source address and then the destination address. Only the pointers that an operation uses are stepped.
- R2: Size code 0 is a byte, 1 is a 2-byte word and 2 is a 4-byte doubleword. The byte enables are 0001, 0011 and 1111 for these sizes. Data sits in the low lanes of the write and read buses, with the lowest address in bits 7:0. Bytes of read data outside the element are ignored. A pointer moves by the element size in bytes after each element.
- R3: With direction 0 the pointers increase. With direction 1 they decrease.
- R4: The count decreases by one for each element. The sequence ends after the element that brings the count to zero.
- R5: Load replaces only the low element bits of the accumulator and keeps its upper bits. Store writes the low element bits of the accumulator.
- R6: Scan compares each element with the low element bits of the accumulator. Compare checks the source element against the destination element. Either one stops after the first unequal element, which is still counted and stepped, and reports mismatch=1. A run that ends because the count is exhausted reports mismatch=0.
- R7: A start with a count of zero makes no memory access. It raises done in the cycle after the start, and every output register equals its start value.
- R8: Done is high for exactly one cycle. The final values stay on the outputs until the next accepted start. After reset, done, the memory request and all registers are zero.
- R9: A start that arrives while a sequence is running or finishing is ignored.
- R10: A read waits for the read-valid input, whatever the latency. At most one read is outstanding. A write completes in the cycle it is issued.
- R11: Operation codes 5 to 7 complete like a zero count: no access, done in the next cycle, registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command, taken when idle |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Element size code |
| dir_i | input | 1 | Direction, 1 = decreasing |
| src_i | input | AW | Initial source pointer |
| dst_i | input | AW | Initial destination pointer |
| cnt_i | input | CW | Initial element count |
| acc_i | input | 32 | Initial accumulator |
| ds_base_i | input | AW | Base added to the source pointer |
| es_base_i | input | AW | Base added to the destination pointer |
| mem_req_o | output | 1 | Memory request, one cycle per access |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | 4 | Byte enables, low-lane aligned |
| mem_wdata_o | output | 32 | Write data, low-lane aligned |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Last run stopped on an unequal element |
| src_o | output | AW | Source pointer |
| dst_o | output | AW | Destination pointer |
| cnt_o | output | CW | Remaining count |
| acc_o | output | 32 | Accumulator |

## Verification
The assertions assume that read-valid is raised only for an outstanding read, no earlier than the cycle after its request, and exactly once for that read. They also assume the memory accepts every write at once. The bench memory model keeps to these rules. It queues a single response after a programmable latency of at least one cycle, and it commits writes on the request edge. Start inputs only matter in the cycle a start is accepted. The bench changes them while a run is active only in the busy-start scenario, where ignoring them is the point of the test.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_MOVE  = 3'd2,
    OP_SCAN  = 3'd3,
    OP_CMP   = 3'd4
  } strop_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE1, ST_WAIT1, ST_ISSUE2, ST_WAIT2, ST_FINISH
  } seq_state_e;

  function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [BE_W-1:0] elem_be(input logic [1:0] sz);
    logic [BE_W-1:0] be;
    for (int i = 0; i < BE_W; i++) be[i] = (i < int'(elem_bytes(sz)));
    return be;
  endfunction

  function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] sz);
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] m;
    be = elem_be(sz);
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic logic op_uses_src(input strop_e op);
    return (op == OP_LOAD) || (op == OP_MOVE) || (op == OP_CMP);
  endfunction

  function automatic logic op_uses_dst(input strop_e op);
    return (op != OP_LOAD);
  endfunction
endpackage

// File: rtl/strop_agen.sv
module strop_agen #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] ds_base_i,
  input  logic [AW-1:0] es_base_i,
  input  logic [1:0]    size_i,
  input  logic          dir_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic [AW-1:0] src_next_o,
  output logic [AW-1:0] dst_next_o
);
  import strop_pkg::*;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p,
                                             input logic [1:0] sz,
                                             input logic down);
    logic [AW-1:0] d;
    d = AW'(elem_bytes(sz));
    return down ? (p - d) : (p + d);
  endfunction

  assign src_addr_o = ds_base_i + src_i;
  assign dst_addr_o = es_base_i + dst_i;
  assign src_next_o = step_ptr(src_i, size_i, dir_i);
  assign dst_next_o = step_ptr(dst_i, size_i, dir_i);
endmodule

// File: rtl/strop_dpath.sv
module strop_dpath (
  input  logic [1:0]                   size_i,
  input  logic                         is_move_i,
  input  logic [strop_pkg::DATA_W-1:0] acc_i,
  input  logic [strop_pkg::DATA_W-1:0] rdata_i,
  input  logic [strop_pkg::DATA_W-1:0] hold_i,
  output logic [strop_pkg::DATA_W-1:0] rd_elem_o,
  output logic [strop_pkg::DATA_W-1:0] acc_load_o,
  output logic [strop_pkg::DATA_W-1:0] wdata_o,
  output logic                         scan_eq_o,
  output logic                         cmp_eq_o
);
  import strop_pkg::*;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] acc_elem;

  assign mask       = elem_mask(size_i);
  assign acc_elem   = acc_i & mask;
  assign rd_elem_o  = rdata_i & mask;
  assign acc_load_o = (acc_i & ~mask) | rd_elem_o;
  assign wdata_o    = is_move_i ? hold_i : acc_elem;
  assign scan_eq_o  = (rd_elem_o == acc_elem);
  assign cmp_eq_o   = (rd_elem_o == hold_i);
endmodule

// File: rtl/strop_ctrl.sv
module strop_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_empty_i,
  input  strop_pkg::strop_e op_i,
  input  logic              rvalid_i,
  input  logic              last_elem_i,
  input  logic              scan_eq_i,
  input  logic              cmp_eq_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              req_o,
  output logic              we_o,
  output logic              use_dst_o,
  output logic              elem_done_o,
  output logic              cap_hold_o,
  output logic              load_acc_o,
  output logic              neq_o,
  output logic              finish_o
);
  import strop_pkg::*;

  seq_state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt         = st;
    req_o       = 1'b0;
    we_o        = 1'b0;
    use_dst_o   = 1'b0;
    elem_done_o = 1'b0;
    cap_hold_o  = 1'b0;
    load_acc_o  = 1'b0;
    neq_o       = 1'b0;
    case (st)
      ST_IDLE: if (start_i) nxt = start_empty_i ? ST_FINISH : ST_ISSUE1;
      ST_ISSUE1: begin
        req_o = 1'b1;
        if (op_i == OP_STORE) begin
          we_o        = 1'b1;
          use_dst_o   = 1'b1;
          elem_done_o = 1'b1;
        end else begin
          use_dst_o = (op_i == OP_SCAN);
          nxt       = ST_WAIT1;
        end
      end
      ST_WAIT1: if (rvalid_i) begin
        case (op_i)
          OP_LOAD: begin
            load_acc_o  = 1'b1;
            elem_done_o = 1'b1;
          end
          OP_SCAN: begin
            elem_done_o = 1'b1;
            neq_o       = !scan_eq_i;
          end
          default: begin
            cap_hold_o = 1'b1;
            nxt        = ST_ISSUE2;
          end
        endcase
      end
      ST_ISSUE2: begin
        req_o     = 1'b1;
        use_dst_o = 1'b1;
        if (op_i == OP_MOVE) begin
          we_o        = 1'b1;
          elem_done_o = 1'b1;
        end else begin
          nxt = ST_WAIT2;
        end
      end
      ST_WAIT2: if (rvalid_i) begin
        elem_done_o = 1'b1;
        neq_o       = !cmp_eq_i;
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
    if (elem_done_o) nxt = (last_elem_i || neq_o) ? ST_FINISH : ST_ISSUE1;
  end

  assign busy_o   = (st != ST_IDLE);
  assign accept_o = start_i && !busy_o;
  assign finish_o = (st == ST_FINISH);
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              dir_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [AW-1:0]     ds_base_i,
  input  logic [AW-1:0]     es_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              mismatch_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     cnt_o,
  output logic [DATA_W-1:0] acc_o
);
  strop_e            op_r;
  logic [1:0]        size_r;
  logic              dir_r;
  logic [AW-1:0]     src_r, dst_r, ds_r, es_r;
  logic [CW-1:0]     cnt_r;
  logic [DATA_W-1:0] acc_r, hold_r;
  logic              mism_r;

  // internal events, named for the checker
  logic busy, accept, elem_done, use_dst, load_acc, cap_hold, neq, finish;
  logic start_empty, last_elem;
  logic [AW-1:0]     src_addr, dst_addr, src_next, dst_next;
  logic [DATA_W-1:0] rd_elem, acc_load, wdata;
  logic              scan_eq, cmp_eq;

  assign start_empty = (cnt_i == '0) || !op_known(op_i);
  assign last_elem   = (cnt_r == CW'(1));

  strop_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_empty_i(start_empty),
    .op_i(op_r), .rvalid_i(mem_rvalid_i), .last_elem_i(last_elem),
    .scan_eq_i(scan_eq), .cmp_eq_i(cmp_eq), .busy_o(busy), .accept_o(accept),
    .req_o(mem_req_o), .we_o(mem_we_o), .use_dst_o(use_dst),
    .elem_done_o(elem_done), .cap_hold_o(cap_hold), .load_acc_o(load_acc),
    .neq_o(neq), .finish_o(finish)
  );

  strop_agen #(.AW(AW)) u_agen (
    .src_i(src_r), .dst_i(dst_r), .ds_base_i(ds_r), .es_base_i(es_r),
    .size_i(size_r), .dir_i(dir_r), .src_addr_o(src_addr),
    .dst_addr_o(dst_addr), .src_next_o(src_next), .dst_next_o(dst_next)
  );

  strop_dpath u_dpath (
    .size_i(size_r), .is_move_i(op_r == OP_MOVE), .acc_i(acc_r),
    .rdata_i(mem_rdata_i), .hold_i(hold_r), .rd_elem_o(rd_elem),
    .acc_load_o(acc_load), .wdata_o(wdata), .scan_eq_o(scan_eq),
    .cmp_eq_o(cmp_eq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_r   <= OP_LOAD;
      size_r <= '0;
      dir_r  <= 1'b0;
      src_r  <= '0;
      dst_r  <= '0;
      ds_r   <= '0;
      es_r   <= '0;
      cnt_r  <= '0;
      acc_r  <= '0;
      hold_r <= '0;
      mism_r <= 1'b0;
    end else if (accept) begin
      op_r   <= strop_e'(op_i);
      size_r <= size_i;
      dir_r  <= dir_i;
      src_r  <= src_i;
      dst_r  <= dst_i;
      ds_r   <= ds_base_i;
      es_r   <= es_base_i;
      cnt_r  <= cnt_i;
      acc_r  <= acc_i;
      mism_r <= 1'b0;
    end else begin
      if (cap_hold) hold_r <= rd_elem;
      if (load_acc) acc_r  <= acc_load;
      if (elem_done) begin
        cnt_r  <= cnt_r - CW'(1);
        mism_r <= neq;
        if (op_uses_src(op_r)) src_r <= src_next;
        if (op_uses_dst(op_r)) dst_r <= dst_next;
      end
    end
  end

  assign mem_addr_o  = use_dst ? dst_addr : src_addr;
  assign mem_be_o    = elem_be(size_r);
  assign mem_wdata_o = wdata;
  assign done_o      = finish;
  assign mismatch_o  = mism_r;
  assign src_o       = src_r;
  assign dst_o       = dst_r;
  assign cnt_o       = cnt_r;
  assign acc_o       = acc_r;
endmodule

// File: rtl/strop_seq_chk.sv
module strop_seq_chk
  import strop_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [CW-1:0]   cnt_i,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [BE_W-1:0] mem_be_o,
  input logic            done_o,
  input logic [AW-1:0]   src_o,
  input logic [CW-1:0]   cnt_o,
  input logic            busy,
  input logic            elem_done,
  input logic            neq,
  input strop_e          op_r,
  input logic [1:0]      size_r,
  input logic            dir_r
);
  p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_be_o inside {4'h1, 4'h3, 4'hF}) &&
                  ($countones(mem_be_o) == int'(elem_bytes(size_r))));

  p_src_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && op_r == OP_LOAD && !dir_r) |=>
      (src_o == $past(src_o) + AW'(elem_bytes(size_r))));

  p_src_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && op_r == OP_LOAD && dir_r) |=>
      (src_o == $past(src_o) - AW'(elem_bytes(size_r))));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (cnt_o == $past(cnt_o) - CW'(1)));

  p_stop_on_neq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && neq) |=> done_o);

  p_zero_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && cnt_i == '0) |=> (done_o && !mem_req_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_done) |=> ($stable(cnt_o) && $stable(src_o)));

  p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);
endmodule

bind strop_seq strop_seq_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_i(cnt_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
  .done_o(done_o), .src_o(src_o), .cnt_o(cnt_o), .busy(busy),
  .elem_done(elem_done), .neq(neq), .op_r(op_r), .size_r(size_r),
  .dir_r(dir_r)
);

// File: tb/strop_seq_tb_top.sv
module strop_seq_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start_i = 0;
  logic [2:0]    op_i = 0;
  logic [1:0]    size_i = 0;
  logic          dir_i = 0;
  logic [AW-1:0] src_i = 0, dst_i = 0, ds_base_i = 0, es_base_i = 0;
  logic [CW-1:0] cnt_i = 0;
  logic [31:0]   acc_i = 0;
  logic          mem_req_o, mem_we_o, done_o, mismatch_o;
  logic [AW-1:0] mem_addr_o, src_o, dst_o;
  logic [3:0]    mem_be_o;
  logic [31:0]   mem_wdata_o, acc_o;
  logic [CW-1:0] cnt_o;
  logic          mem_rvalid_i = 0;
  logic [31:0]   mem_rdata_i = 0;

  strop_seq #(.AW(AW), .CW(CW)) dut_i (.*);

  // memory model
  logic [7:0] mem [0:255];
  logic [7:0] shadow [0:255];
  int   lat = 1;
  int   nreq = 0;
  logic pend = 0;
  int   dly = 0;
  logic [7:0] raddr = 0;
  logic fill_en = 0;
  int   fill_kind = 0;

  function automatic logic [7:0] pat(int kind, int i);
    logic [7:0] v;
    v = 8'(((i % 128) * 7) + 3);
    if (kind == 0) v = 8'((i * 13) + 1);
    if (kind == 2 && i == 128 + 13) v = v ^ 8'h40;
    if (kind == 3 && i >= 8'h40 && i < 8'h50) v = 8'h77;
    return v;
  endfunction

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (fill_en) for (int i = 0; i < 256; i++) mem[i] <= pat(fill_kind, i);
    if (pend) begin
      if (dly <= 1) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= {mem[8'(raddr + 8'd3)], mem[8'(raddr + 8'd2)],
                         mem[8'(raddr + 8'd1)], mem[raddr]};
        pend <= 1'b0;
      end else dly <= dly - 1;
    end
    if (mem_req_o) begin
      nreq <= nreq + 1;
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[8'(mem_addr_o[7:0] + 8'(b))] <= mem_wdata_o[8*b +: 8];
      end else begin
        pend  <= 1'b1;
        dly   <= lat;
        raddr <= mem_addr_o[7:0];
      end
    end
  end

  int nchk = 0;
  int nerr = 0;
  int cyc_all = 0;
  always @(posedge clk) begin
    cyc_all <= cyc_all + 1;
    if (cyc_all > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc_all);
      $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
      $finish;
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(int kind);
    fill_kind = kind;
    @(negedge clk) fill_en = 1'b1;
    @(negedge clk) fill_en = 1'b0;
    for (int i = 0; i < 256; i++) shadow[i] = pat(kind, i);
  endtask

  function automatic logic [31:0] rd_sh(logic [31:0] a, int n);
    logic [31:0] v = 0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = shadow[8'(a[7:0] + 8'(k))];
    return v;
  endfunction

  task automatic wr_sh(logic [31:0] a, int n, logic [31:0] v);
    for (int k = 0; k < n; k++) shadow[8'(a[7:0] + 8'(k))] = v[8*k +: 8];
  endtask

  // independent model working on the shadow memory
  logic [31:0] e_src, e_dst, e_acc;
  int          e_cnt, e_req;
  logic        e_mism;

  task automatic model(int op, int sz, int dir, logic [31:0] s, logic [31:0] d,
                       int c, logic [31:0] a, logic [31:0] ds, logic [31:0] es);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    logic [31:0] m = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    logic [31:0] step = dir ? -n : n;
    logic [31:0] x, y;
    e_mism = 0; e_req = 0;
    if (op <= 4) begin
      while (c != 0 && !e_mism) begin
        x = rd_sh(ds + s, n);
        y = rd_sh(es + d, n);
        case (op)
          0: begin a = (a & ~m) | x; e_req += 1; end
          1: begin wr_sh(es + d, n, a); e_req += 1; end
          2: begin wr_sh(es + d, n, x); e_req += 2; end
          3: begin e_mism = (y != (a & m)); e_req += 1; end
          default: begin e_mism = (x != y); e_req += 2; end
        endcase
        if (op == 0 || op == 2 || op == 4) s = s + step;
        if (op != 0) d = d + step;
        c--;
      end
    end
    e_src = s; e_dst = d; e_cnt = c; e_acc = a;
  endtask

  int last_cyc;

  task automatic run_op(string req, int op, int sz, int dir, logic [31:0] s,
                        logic [31:0] d, int c, logic [31:0] a,
                        logic [31:0] ds, logic [31:0] es, int intrude);
    int n0, cyc, bad;
    model(op, sz, dir, s, d, c, a, ds, es);
    n0 = nreq;
    @(negedge clk);
    start_i = 1; op_i = 3'(op); size_i = 2'(sz); dir_i = dir[0];
    src_i = s; dst_i = d; cnt_i = CW'(c); acc_i = a; ds_base_i = ds; es_base_i = es;
    @(negedge clk);
    start_i = 0;
    cyc = 1;
    while (!done_o && cyc < 3000) begin
      if (intrude > 0 && cyc == intrude) begin
        start_i = 1; op_i = 3'd1; cnt_i = 16'd9; acc_i = 32'hDEAD_BEEF;
        src_i = 32'h11; dst_i = 32'h22;
      end else start_i = 0;
      @(negedge clk);
      cyc++;
    end
    start_i = 0;
    last_cyc = cyc;
    check(req, "done seen", done_o, 1'b1);
    check(req, "src", src_o, e_src);
    check(req, "dst", dst_o, e_dst);
    check(req, "cnt", cnt_o, 64'(e_cnt));
    check(req, "acc", acc_o, e_acc);
    check(req, "mismatch", mismatch_o, e_mism);
    check(req, "requests", nreq - n0, e_req);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    check(req, "memory bytes differing", bad, 0);
    @(negedge clk);
    check("R8", "done one cycle", done_o, 1'b0);
    check("R8", "outputs held", {src_o, cnt_o}, {e_src, 16'(e_cnt)});
  endtask

  task automatic t_reset;
    check("R8", "reset done", done_o, 0);
    check("R8", "reset req", mem_req_o, 0);
    check("R8", "reset regs", {src_o, dst_o, cnt_o, acc_o, mismatch_o}, 0);
  endtask

  task automatic t_load;
    fill(0);
    lat = 1;
    run_op("R5", 0, 0, 0, 32'h10, 32'h0, 5, 32'hAABB_CCDD, 32'h1000_0004, 32'h0, 0);
    lat = 3;
    run_op("R3", 0, 1, 1, 32'h60, 32'h0, 4, 32'h1234_5678, 32'h0, 32'h0, 0);
    lat = 1;
  endtask

  task automatic t_store;
    fill(0);
    run_op("R1", 1, 1, 1, 32'h0, 32'hA0, 4, 32'hCAFE_F00D, 32'h0, 32'h0200_0010, 0);
    run_op("R2", 1, 0, 0, 32'h0, 32'h30, 3, 32'h0000_005A, 32'h0, 32'h0, 0);
  endtask

  task automatic t_move;
    fill(0);
    run_op("R2", 2, 2, 0, 32'h10, 32'h80, 6, 32'h0, 32'h8, 32'h0, 0);
    run_op("R3", 2, 1, 1, 32'h50, 32'hF0, 5, 32'h0, 32'h0, 32'h0, 0);
  endtask

  task automatic t_scan;
    fill(3);
    run_op("R6", 3, 0, 0, 32'h0, 32'h40, 20, 32'h0000_0077, 32'h0, 32'h0, 0);
    check("R6", "scan stopped early", cnt_o, 16'd3);
    run_op("R4", 3, 0, 0, 32'h0, 32'h40, 10, 32'hFFFF_FF77, 32'h0, 32'h0, 0);
  endtask

  task automatic t_compare;
    fill(1);
    lat = 2;
    run_op("R6", 4, 2, 0, 32'h0, 32'h80, 8, 32'h0, 32'h0, 32'h0, 0);
    fill(2);
    run_op("R6", 4, 1, 0, 32'h0, 32'h80, 16, 32'h0, 32'h0, 32'h0, 0);
    check("R6", "compare mismatch flag", mismatch_o, 1'b1);
    lat = 4;
    run_op("R10", 4, 0, 0, 32'h0, 32'h80, 6, 32'h0, 32'h0, 32'h0, 0);
    lat = 1;
  endtask

  task automatic t_zero;
    fill(0);
    run_op("R7", 1, 0, 0, 32'h5, 32'h7, 0, 32'h1111_2222, 32'h0, 32'h0, 0);
    check("R7", "done latency", last_cyc, 1);
    run_op("R11", 6, 0, 0, 32'h9, 32'h3, 5, 32'h3333_4444, 32'h0, 32'h0, 0);
    check("R11", "done latency", last_cyc, 1);
  endtask

  task automatic t_busy;
    fill(0);
    lat = 2;
    run_op("R9", 2, 0, 0, 32'h20, 32'hC0, 4, 32'h0, 32'h0, 32'h0, 3);
    lat = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_load();
    t_store();
    t_move();
    t_scan();
    t_compare();
    t_zero();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule